// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block runs conversion sequences on an external eight-input analog-to-digital converter core and keeps the results. Software sets a configuration register to power the converter, choose 8-bit or 10-bit results and enable an interrupt. It then writes a control byte that selects one channel or a channel scan, a sequence of four or eight conversions, and one-shot or continuous operation. Each write of the control byte starts a fresh sequence.

The controller asks the core for one conversion at a time with a one-cycle start pulse and a channel number. It waits for the core's done pulse, takes the 10-bit sample and stores it in the result register that matches the conversion's position in the sequence. When the last conversion of a sequence lands, a complete flag is set. This flag can drive an interrupt line. After power-up, the controller holds off all conversions until a settling interval, counted in clocks, has passed.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every readable register reads 0x00, `irq` is low and `conv_start` stays low.
- R2: When the power bit (configuration register, address 0, bit 0) goes to 1, no conversion starts for SETTLE_CYCLES clocks. If the control byte was written earlier, its sequence begins with the first start pulse exactly SETTLE_CYCLES+1 cycles after the clock edge that loaded the power bit.
- R3: Control byte (address 1) fields: bit 6 = eight conversions (else four), bit 5 = continuous, bit 4 = scan, bits 2:0 = base channel. With scan clear, every conversion of the sequence uses the base channel.
- R4: With scan set, conversion k uses channel k for eight-conversion sequences. For four-conversion sequences it uses channel (base & 4) + k.
- R5: The sample of conversion k is stored in result k. Its high byte is at address 16+2k and holds sample bits 9:2. Its low byte is at 17+2k and holds sample bits 1:0 in bits 7:6 when the 10-bit bit (address 0, bit 1) is 1. The low byte is 0x00 in 8-bit mode.
- R6: Status bit 0 (address 2) becomes 1 when the last conversion of a sequence is stored. Writing 1 to status bit 0 clears it.
- R7: `irq` equals the status flag ANDed with the interrupt enable (address 0, bit 2).
- R8: A control write clears the status flag and aborts any sequence in progress. A conversion already issued is allowed to finish, but its sample is discarded. The new sequence then starts at conversion 0.
- R9: In continuous mode, the first start pulse of the next sequence appears in the same cycle that the status flag first reads 1.
- R10: Clearing the power bit cancels the active and any pending sequence and restarts the settling interval. No start is issued while the power bit is 0.
- R11: `conv_start` is a one-cycle pulse, and at most one conversion is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational from address) |
| conv_start | output | 1 | Start pulse to converter core |
| conv_chan | output | 3 | Channel for the requested conversion |
| conv_done | input | 1 | Converter core done pulse |
| conv_data | input | 10 | Converter core sample, valid with done |
| irq | output | 1 | Sequence-complete interrupt |

## Verification
A wrong sequence index or channel shows at `conv_chan` on the very start pulse where it diverges. A stale or shifted sample shows up in the result bytes as soon as the sequence completes. If the abort logic fails to discard an in-flight sample, every later result moves by one slot. If it loses track of that sample, the controller hangs and no further start pulse appears. A settling counter that is off by even one cycle moves the first start pulse, and the bench checks that pulse's exact cycle after power-up.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NCH  = 8;
  localparam int CHW  = $clog2(NCH);
  localparam int IDXW = CHW;
  localparam int DW   = 10;
  localparam int BW   = 8;
  localparam int LOW  = DW - BW;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_state_e;

  typedef struct packed {
    logic           len8;
    logic           cont;
    logic           scan;
    logic [CHW-1:0] base;
  } seq_cfg_t;
endpackage

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
  parameter int SETTLE_CYCLES = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on,
  output logic ready
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!pwr_on)            cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready = pwr_on && (cnt_q == LIMIT);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  seq_cfg_t        cfg,
  input  logic            start_req,
  input  logic            pwr_on,
  input  logic            ready,
  input  logic            flag_clr,
  input  logic            conv_done,
  output logic            conv_start,
  output logic [CHW-1:0]  conv_chan,
  output logic            res_we,
  output logic [IDXW-1:0] res_idx,
  output logic            done_flag
);
  seq_state_e      state_q, state_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic            pend_q, pend_d;
  logic            drop_q, drop_d;
  logic            flag_q, flag_d;
  logic            last, in_flight;

  assign last      = idx_q == (cfg.len8 ? IDXW'(NCH - 1) : IDXW'(NCH / 2 - 1));
  assign in_flight = (state_q == S_ISSUE) || ((state_q == S_WAIT) && !conv_done);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    pend_d  = pend_q;
    drop_d  = drop_q;
    flag_d  = flag_q;
    res_we  = 1'b0;
    if (flag_clr) flag_d = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (pend_q && ready) begin
          pend_d  = 1'b0;
          idx_d   = '0;
          state_d = S_ISSUE;
        end
      end
      S_ISSUE: state_d = S_WAIT;
      S_WAIT: begin
        if (conv_done) begin
          if (drop_q) begin
            drop_d  = 1'b0;
            state_d = S_IDLE;
          end else begin
            res_we = 1'b1;
            if (last) begin
              flag_d  = 1'b1;
              idx_d   = '0;
              state_d = cfg.cont ? S_ISSUE : S_IDLE;
            end else begin
              idx_d   = idx_q + 1'b1;
              state_d = S_ISSUE;
            end
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (start_req || !pwr_on) begin
      idx_d   = '0;
      res_we  = 1'b0;
      state_d = in_flight ? S_WAIT : S_IDLE;
      drop_d  = in_flight;
      pend_d  = start_req && pwr_on;
      if (start_req) flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      pend_q  <= 1'b0;
      drop_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      pend_q  <= pend_d;
      drop_q  <= drop_d;
      flag_q  <= flag_d;
    end
  end

  always_comb begin
    if (!cfg.scan)     conv_chan = cfg.base;
    else if (cfg.len8) conv_chan = idx_q;
    else               conv_chan = {cfg.base[CHW-1], idx_q[CHW-2:0]};
  end

  assign conv_start = (state_q == S_ISSUE);
  assign res_idx    = idx_q;
  assign done_flag  = flag_q;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [DW-1:0]   sample,
  input  logic            ten_bit,
  input  logic [IDXW-1:0] rd_idx,
  output logic [BW-1:0]   rd_hi,
  output logic [BW-1:0]   rd_lo
);
  logic [BW-1:0]  hi_q [NCH];
  logic [LOW-1:0] lo_q [NCH];
  logic [LOW-1:0] lo_in;

  assign lo_in = ten_bit ? sample[LOW-1:0] : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    logic hit;
    assign hit = we && (wr_idx == IDXW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[g] <= '0;
        lo_q[g] <= '0;
      end else if (hit) begin
        hi_q[g] <= sample[DW-1:LOW];
        lo_q[g] <= lo_in;
      end
    end
  end

  assign rd_hi = hi_q[rd_idx];
  assign rd_lo = {lo_q[rd_idx], {(BW-LOW){1'b0}}};
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 800
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [4:0]     bus_addr,
  input  logic [BW-1:0]  bus_wdata,
  output logic [BW-1:0]  bus_rdata,
  output logic           conv_start,
  output logic [CHW-1:0] conv_chan,
  input  logic           conv_done,
  input  logic [DW-1:0]  conv_data,
  output logic           irq
);
  localparam logic [4:0] A_CFG  = 5'd0;
  localparam logic [4:0] A_CTRL = 5'd1;
  localparam logic [4:0] A_STAT = 5'd2;

  logic [BW-1:0]   cfg_q, cfg_d, ctrl_q, ctrl_d;
  logic            cfg_pwr_q, cfg_pwr_d;
  logic            ctrl_wr, flag_clr, settled, done_flag, res_we;
  logic [IDXW-1:0] res_idx;
  logic [BW-1:0]   res_hi, res_lo;
  seq_cfg_t        seq_cfg;

  assign ctrl_wr  = bus_we && (bus_addr == A_CTRL);
  assign flag_clr = bus_we && (bus_addr == A_STAT) && bus_wdata[0];

  always_comb begin
    cfg_d  = cfg_q;
    ctrl_d = ctrl_q;
    if (bus_we && (bus_addr == A_CFG)) cfg_d = bus_wdata;
    if (ctrl_wr)                       ctrl_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      ctrl_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign cfg_pwr_q = cfg_q[0];
  assign cfg_pwr_d = cfg_d[0];
  assign seq_cfg   = '{len8: ctrl_q[6], cont: ctrl_q[5], scan: ctrl_q[4],
                       base: ctrl_q[CHW-1:0]};

  adc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .pwr_on(cfg_pwr_q), .ready(settled));

  adc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg(seq_cfg), .start_req(ctrl_wr),
    .pwr_on(cfg_pwr_d), .ready(settled), .flag_clr(flag_clr),
    .conv_done(conv_done), .conv_start(conv_start), .conv_chan(conv_chan),
    .res_we(res_we), .res_idx(res_idx), .done_flag(done_flag));

  adc_result_bank u_bank (
    .clk(clk), .rst_n(rst_n), .we(res_we), .wr_idx(res_idx),
    .sample(conv_data), .ten_bit(cfg_q[1]), .rd_idx(bus_addr[3:1]),
    .rd_hi(res_hi), .rd_lo(res_lo));

  always_comb begin
    if (bus_addr[4])              bus_rdata = bus_addr[0] ? res_lo : res_hi;
    else if (bus_addr == A_CFG)   bus_rdata = cfg_q;
    else if (bus_addr == A_CTRL)  bus_rdata = ctrl_q;
    else if (bus_addr == A_STAT)  bus_rdata = {{(BW-1){1'b0}}, done_flag};
    else                          bus_rdata = '0;
  end

  assign irq = done_flag && cfg_q[2];
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_start,
  input logic conv_done,
  input logic ready,
  input logic flag,
  input logic ctrl_wr,
  input logic pwr
);
  AST_START_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ready);                                  // R2
  AST_UNPOWERED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr |-> !conv_start);                                  // R10
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);                            // R11
  AST_FLAG_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(conv_done));                      // R6
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !flag);                                     // R8
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
  .ready(settled), .flag(done_flag), .ctrl_wr(ctrl_wr), .pwr(cfg_pwr_q));

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 20;

  logic       clk, rst_n, bus_we, conv_start, conv_done, irq;
  logic [4:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [2:0] conv_chan;
  logic [9:0] conv_data;

  adc_seq_ctrl #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
    .irq(irq));

  int nchecks = 0, nfail = 0;
  int cyc = 0, pwr_cyc = 0, ord = 0, start_cnt = 0;
  int last_start_cyc = 0, seq_first_cyc = 0, force_lat = 0;
  logic [7:0] bctrl = 8'h00, bcfg = 8'h00;
  logic [9:0] model_data [8];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int seq_len(input logic [7:0] c);
    return c[6] ? 8 : 4;
  endfunction

  function automatic logic [2:0] exp_chan(input logic [7:0] c, input int k);
    if (!c[4])     return c[2:0];
    else if (c[6]) return 3'(k);
    else           return 3'((c[2:0] & 3'd4) + 3'(k));
  endfunction

  // Behavioural converter core
  initial begin
    int pend_lat = 0;
    logic [9:0] pdata = '0;
    conv_done = 1'b0;
    conv_data = '0;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (pend_lat > 0) begin
        pend_lat--;
        if (pend_lat == 0) begin
          conv_done = 1'b1;
          conv_data = pdata;
        end
      end
      if (conv_start) begin
        chk(pend_lat == 0 && !conv_done, "R11", pend_lat, 0);
        chk(conv_chan == exp_chan(bctrl, ord), bctrl[4] ? "R4" : "R3",
            conv_chan, exp_chan(bctrl, ord));
        pdata = 10'($urandom);
        model_data[ord] = pdata;
        if (ord == 0) seq_first_cyc = cyc;
        last_start_cyc = cyc;
        start_cnt++;
        ord = (ord + 1) % seq_len(bctrl);
        pend_lat = (force_lat > 0) ? force_lat : 1 + int'($urandom % 4);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
    if (a == 5'd1) begin ord = 0; bctrl = d; end
    if (a == 5'd0) begin pwr_cyc = cyc; bcfg = d; end
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 v = bus_rdata;
  endtask

  task automatic wait_flag(input string req, output bit got);
    logic [7:0] v;
    got = 0;
    for (int i = 0; i < 3000; i++) begin
      rd(5'd2, v);
      if (v[0]) begin got = 1; break; end
    end
    chk(got, req, 0, 1);
  endtask

  task automatic check_results(input string req);
    logic [7:0] hi, lo;
    for (int k = 0; k < seq_len(bctrl); k++) begin
      rd(5'(16 + 2*k), hi);
      rd(5'(17 + 2*k), lo);
      chk(hi == model_data[k][9:2], req, hi, model_data[k][9:2]);
      chk(lo == (bcfg[1] ? {model_data[k][1:0], 6'b0} : 8'h00), req, lo,
          bcfg[1] ? {model_data[k][1:0], 6'b0} : 8'h00);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    bit got;
    int sc;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 32; a++) begin
      if (a < 3 || a >= 16) begin
        rd(5'(a), v);
        chk(v == 8'h00, "R1", v, 0);
      end
    end
    chk(!irq && !conv_start, "R1", {irq, conv_start}, 0);

    // R2: control written before settling ends; start exactly SETTLE+1 after power
    wr(5'd0, 8'h07);
    wr(5'd1, 8'h00);
    wait_flag("R6", got);
    chk(seq_first_cyc - pwr_cyc == SETTLE + 1, "R2", seq_first_cyc - pwr_cyc, SETTLE + 1);
    check_results("R5");
    chk(irq == 1'b1, "R7", irq, 1);
    wr(5'd2, 8'h01);
    rd(5'd2, v);
    chk(v == 8'h00 && !irq, "R6", v, 0);

    // Constrained random one-shot sequences
    for (int t = 0; t < 14; t++) begin
      logic [7:0] c, g;
      g = {5'b0, 1'($urandom), 1'($urandom), 1'b1};
      c = {1'b0, 1'($urandom), 1'b0, 1'($urandom), 1'b0, 3'($urandom)};
      wr(5'd0, g);
      if (t == 0) repeat (SETTLE + 2) @(negedge clk);
      wr(5'd1, c);
      wait_flag("R6", got);
      check_results("R5");
      chk(irq == g[2], "R7", irq, g[2]);
      wr(5'd2, 8'h01);
      rd(5'd2, v);
      chk(v == 8'h00, "R6", v, 0);
    end

    // R9: continuous scan of all channels
    wr(5'd0, 8'h03);
    wr(5'd1, 8'h70);
    wait_flag("R9", got);
    chk(last_start_cyc == cyc && ord == 1, "R9", last_start_cyc, cyc);
    sc = start_cnt;
    repeat (30) @(negedge clk);
    chk(start_cnt > sc, "R9", start_cnt, sc + 1);

    // R3: single channel 7, eight per sequence, continuous
    wr(5'd1, 8'h67);
    wait_flag("R3", got);
    chk(last_start_cyc == cyc && ord == 1, "R9", last_start_cyc, cyc);

    // R8: control write clears the flag
    wr(5'd1, 8'h00);
    rd(5'd2, v);
    chk(v == 8'h00, "R8", v, 0);
    wait_flag("R6", got);
    check_results("R5");

    // R8: abort while a conversion is outstanding, sample discarded
    force_lat = 25;
    sc = start_cnt;
    wr(5'd1, 8'h40);
    while (start_cnt == sc) @(negedge clk);
    repeat (3) @(negedge clk);
    force_lat = 0;
    wr(5'd1, 8'h15);
    rd(5'd2, v);
    chk(v == 8'h00, "R8", v, 0);
    wait_flag("R8", got);
    check_results("R8");

    // R10: power-off cancels a continuous run and any pending start
    wr(5'd1, 8'h70);
    repeat (10) @(negedge clk);
    wr(5'd0, 8'h00);
    repeat (8) @(negedge clk);
    sc = start_cnt;
    repeat (20) @(negedge clk);
    chk(start_cnt == sc, "R10", start_cnt, sc);
    wr(5'd0, 8'h01);
    repeat (SETTLE + 10) @(negedge clk);
    chk(start_cnt == sc, "R10", start_cnt, sc);
    wr(5'd0, 8'h01);
    wr(5'd1, 8'h10);
    wr(5'd0, 8'h00);
    wr(5'd0, 8'h01);
    wr(5'd1, 8'h10);
    wait_flag("R10", got);
    chk(seq_first_cyc - pwr_cyc == SETTLE + 1, "R10", seq_first_cyc - pwr_cyc, SETTLE + 1);
    check_results("R4");

    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule